// File: doc/BRIEF.md
# Configurable-Mode Serial Register Slave

This block is a 16-bit synchronous serial slave through which an external host reads and writes a small bank of 10-bit registers. The host owns the interface. It supplies the serial clock, a data line into the block, and an active-low select. The block answers on a data-out line that carries an output-enable, so it can share a wire with other slaves. Each word moves in both directions at once. While the host shifts a command in, the block shifts its reply out. The reply to a read command travels in the word that follows it.

Register 0 holds the port's own mode. Its three low bits choose the bit order, the clock idle level and the clock phase. The polarity and phase bits together give four clocking schemes. The register contents are also presented to the surrounding logic as one flat parallel bus. Raising select aborts any partial word, clears the pending reply and lets a newly written mode take effect. The bank itself keeps its contents until the separate power-on reset is applied.

Top module: `serial_reg_slave`

## Requirements
- R1: A word is 16 bits. A write command has bit 15 = 0, the register number in bits 14:10 and the value in bits 9:0. It updates that register on `regsOut` right at the sampling edge of the sixteenth bit, and never at any other time.
- R2: A read command (bit 15 = 1, register number in bits 14:10, bits 9:0 ignored) makes the next word in the same select-low period return the register value zero-extended to 16 bits. The host may leave any number of idle clock periods between the two words.
- R3: The reply is all zeros in three cases: the first word after select falls, the word after a write, and a read of a register number at or above NUM_REGS. Writes to such register numbers change nothing.
- R4: While `selN` is high, `sdoOe` is low and `sdo` is low. Raising `selN` discards a partial word without any register change, and it also discards a pending read reply.
- R5: Register 0 is the mode register: bit 0 = LSB first, bit 1 = clock polarity (idle level), bit 2 = phase. A value written there governs transfers only after `selN` has next gone high.
- R6: With bit order clear, bit 15 of each word travels first. With it set, bit 0 travels first. This applies to both directions.
- R7: The input is sampled on the rising clock edge when polarity equals phase, and on the falling edge otherwise. The output changes on the opposite edge. With phase clear, the first reply bit is valid before the first clock edge. With phase set, it is driven on the first clock edge.
- R8: A low `rstN` clears every register to zero and returns the port to mode 0 (MSB first, idle-low clock, phase clear).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous power-on reset, active low |
| sclk | input | 1 | Serial clock from the host |
| selN | input | 1 | Active-low select; high disables and resets the port |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdoOe | output | 1 | Output enable for `sdo` (tri-state control) |
| regsOut | output | NUM_REGS*10 | Register bank, register i at bits [10*i+9 : 10*i] |

## Verification
The bound checker watches four things on every cycle:
- the silent, disabled output while deselected;
- that the register bus moves only right after a completed word;
- that nothing is written while select is high;
- that the active mode cannot shift in the middle of a word.

Other behaviours can only be shown by the bench's scenarios, which drive full select periods in all four clock schemes and both bit orders:
- that the read data arrives in the following word, correctly ordered;
- that a new mode takes hold only after select rises;
- that a pending reply is lost when select goes high;
- that out-of-range numbers read as zero.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 10;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam int MODE_W = 3;

  typedef struct packed {
    logic pha;
    logic pol;
    logic lsbFirst;
  } mode_t;

  typedef struct packed {
    logic             wordDone;
    logic             loadShadow;
    logic [CNT_W-1:0] outPos;
  } strobe_t;
endpackage

// File: rtl/sreg_ctrl.sv
module sreg_ctrl
  import sreg_pkg::*;
(
  input  logic              rstN,
  input  logic              selN,
  input  logic              sclk,
  input  logic [MODE_W-1:0] ctrlBits,
  output mode_t             modeNow,
  output logic              sampleClk,
  output logic              launchClk,
  output logic [CNT_W-1:0]  wordPos,
  output strobe_t           stb
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic             portRst;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] outPos;
  logic             armed;
  logic             holdFirst;

  assign portRst = selN | ~rstN;

  // mode is latched only when select rises, so it is frozen during a word
  always_ff @(posedge selN or negedge rstN) begin
    if (!rstN) modeNow <= '0;
    else       modeNow <= mode_t'(ctrlBits);
  end

  assign sampleClk = sclk ^ (modeNow.pol ^ modeNow.pha);
  assign launchClk = ~sampleClk;

  always_ff @(posedge sampleClk or posedge portRst) begin
    if (portRst)            bitCnt <= '0;
    else if (bitCnt == LAST) bitCnt <= '0;
    else                    bitCnt <= bitCnt + 1'b1;
  end

  // phase set: the first launch edge presents bit 0 instead of advancing
  assign holdFirst = modeNow.pha & ~armed;

  always_ff @(posedge launchClk or posedge portRst) begin
    if (portRst) begin
      armed  <= 1'b0;
      outPos <= '0;
    end else if (holdFirst) begin
      armed  <= 1'b1;
    end else if (outPos == LAST) begin
      outPos <= '0;
    end else begin
      outPos <= outPos + 1'b1;
    end
  end

  assign wordPos        = bitCnt;
  assign stb.wordDone   = (bitCnt == LAST);
  assign stb.loadShadow = ~holdFirst & (outPos == LAST);
  assign stb.outPos     = outPos;
endmodule

// File: rtl/sreg_data.sv
module sreg_data
  import sreg_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                       rstN,
  input  logic                       selN,
  input  logic                       sampleClk,
  input  logic                       launchClk,
  input  logic                       sdi,
  input  logic                       lsbFirst,
  input  strobe_t                    stb,
  output logic                       sdo,
  output logic                       sdoOe,
  output logic [MODE_W-1:0]          ctrlBits,
  output logic [NUM_REGS*DATA_W-1:0] regsOut
);
  localparam int PAD_W = WORD_W - DATA_W;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic                portRst;
  logic [WORD_W-1:0]   rxShift;
  logic [WORD_W-1:0]   rxNext;
  logic [WORD_W-1:0]   txWord;
  logic [WORD_W-1:0]   shadow;
  logic                isRead;
  logic [ADDR_W-1:0]   addr;
  logic [DATA_W-1:0]   wrData;
  logic                addrHit;
  logic [DATA_W-1:0]   readVal;
  logic [DATA_W-1:0]   bank [NUM_REGS];
  logic [CNT_W-1:0]    bitSel;

  assign portRst = selN | ~rstN;

  assign rxNext = lsbFirst ? {sdi, rxShift[WORD_W-1:1]}
                           : {rxShift[WORD_W-2:0], sdi};

  assign isRead  = rxNext[WORD_W-1];
  assign addr    = rxNext[WORD_W-2 -: ADDR_W];
  assign wrData  = rxNext[DATA_W-1:0];
  assign addrHit = (int'(addr) < NUM_REGS);

  always_comb begin
    readVal = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr == ADDR_W'(i)) readVal = bank[i];
  end

  always_ff @(posedge sampleClk or posedge portRst) begin
    if (portRst) begin
      rxShift <= '0;
      txWord  <= '0;
    end else begin
      rxShift <= rxNext;
      if (stb.wordDone)
        txWord <= (isRead && addrHit) ? {{PAD_W{1'b0}}, readVal} : '0;
    end
  end

  always_ff @(posedge sampleClk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= '0;
    end else if (stb.wordDone && !isRead) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (addr == ADDR_W'(i)) bank[i] <= wrData;
    end
  end

  always_ff @(posedge launchClk or posedge portRst) begin
    if (portRst)             shadow <= '0;
    else if (stb.loadShadow) shadow <= txWord;
  end

  assign bitSel = lsbFirst ? stb.outPos : (LAST - stb.outPos);
  assign sdoOe  = ~selN;
  assign sdo    = sdoOe & shadow[bitSel];

  assign ctrlBits = bank[0][MODE_W-1:0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gFlat
    assign regsOut[g*DATA_W +: DATA_W] = bank[g];
  end
endmodule

// File: rtl/serial_reg_slave.sv
module serial_reg_slave
  import sreg_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                       rstN,
  input  logic                       sclk,
  input  logic                       selN,
  input  logic                       sdi,
  output logic                       sdo,
  output logic                       sdoOe,
  output logic [NUM_REGS*DATA_W-1:0] regsOut
);
  mode_t             modeNow;
  strobe_t           stb;
  logic              sampleClk;
  logic              launchClk;
  logic [CNT_W-1:0]  wordPos;
  logic [MODE_W-1:0] ctrlBits;

  sreg_ctrl uCtrl (
    .rstN      (rstN),
    .selN      (selN),
    .sclk      (sclk),
    .ctrlBits  (ctrlBits),
    .modeNow   (modeNow),
    .sampleClk (sampleClk),
    .launchClk (launchClk),
    .wordPos   (wordPos),
    .stb       (stb)
  );

  sreg_data #(.NUM_REGS(NUM_REGS)) uData (
    .rstN      (rstN),
    .selN      (selN),
    .sampleClk (sampleClk),
    .launchClk (launchClk),
    .sdi       (sdi),
    .lsbFirst  (modeNow.lsbFirst),
    .stb       (stb),
    .sdo       (sdo),
    .sdoOe     (sdoOe),
    .ctrlBits  (ctrlBits),
    .regsOut   (regsOut)
  );
endmodule

// File: rtl/sreg_checker.sv
module sreg_checker
  import sreg_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input logic                       rstN,
  input logic                       sclk,
  input logic                       selN,
  input logic                       sdo,
  input logic                       sdoOe,
  input logic                       sampleClk,
  input logic                       wordDone,
  input logic [CNT_W-1:0]           wordPos,
  input logic [MODE_W-1:0]          modeNow,
  input logic [NUM_REGS*DATA_W-1:0] regsOut
);
  logic edgeSeen;

  always_ff @(posedge sampleClk or negedge rstN) begin
    if (!rstN) edgeSeen <= 1'b0;
    else       edgeSeen <= 1'b1;
  end

  AST_QUIET_WHEN_DESELECTED: assert property (@(posedge sclk) disable iff (!rstN)
    selN |-> (!sdoOe && !sdo)); // R4

  AST_WRITE_AT_WORD_END: assert property (@(posedge sampleClk) disable iff (!rstN)
    (edgeSeen && !$past(wordDone)) |-> $stable(regsOut)); // R1

  AST_NO_WRITE_DESELECTED: assert property (@(posedge sampleClk) disable iff (!rstN)
    (edgeSeen && $past(selN)) |-> $stable(regsOut)); // R4

  AST_MODE_FROZEN_MIDWORD: assert property (@(posedge sampleClk) disable iff (!rstN)
    (edgeSeen && wordPos != '0) |-> $stable(modeNow)); // R5
endmodule

bind serial_reg_slave sreg_checker #(.NUM_REGS(NUM_REGS)) uChk (
  .rstN      (rstN),
  .sclk      (sclk),
  .selN      (selN),
  .sdo       (sdo),
  .sdoOe     (sdoOe),
  .sampleClk (sampleClk),
  .wordDone  (stb.wordDone),
  .wordPos   (wordPos),
  .modeNow   (modeNow),
  .regsOut   (regsOut)
);

// File: tb/sim_serial_reg_slave.sv
`timescale 1ns/1ps
module sim_serial_reg_slave;
  localparam int NREG = 8;
  localparam int DW   = 10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, sclk = 1'b0, selN = 1'b1, sdi = 1'b0;
  logic sdo, sdoOe;
  logic [NREG*DW-1:0] regsOut;

  serial_reg_slave #(.NUM_REGS(NREG)) u0 (
    .rstN(rstN), .sclk(sclk), .selN(selN), .sdi(sdi),
    .sdo(sdo), .sdoOe(sdoOe), .regsOut(regsOut)
  );

  int nChecks = 0, nFail = 0;
  bit live = 1'b0, done = 1'b0;
  logic [DW-1:0] model [NREG];
  logic [15:0] pendReply = '0;
  logic bPol = 1'b0, bPha = 1'b0, bLsb = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [NREG*DW-1:0] act,
                     input logic [NREG*DW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NREG*DW-1:0] flatModel();
    logic [NREG*DW-1:0] f;
    for (int i = 0; i < NREG; i++) f[i*DW +: DW] = model[i];
    return f;
  endfunction

  // per-clock comparison against the behavioural model
  always @(posedge clk) begin
    if (live && !done) begin
      chk(regsOut == flatModel(), "R1 register bus", regsOut, flatModel());
      chk(sdoOe == !selN, "R4 output enable", sdoOe, !selN);
      if (selN) chk(sdo == 1'b0, "R4 quiet data", sdo, 0);
    end
  end

  task automatic halfWait();
    repeat (2) @(negedge clk);
  endtask

  task automatic commitWord(input logic [15:0] cmd);
    int a = int'(cmd[14:10]);
    if (cmd[15]) begin
      pendReply = (a < NREG) ? {6'b0, model[a]} : 16'h0;
    end else begin
      if (a < NREG) model[a] = cmd[9:0];
      pendReply = 16'h0;
    end
  endtask

  task automatic shiftBits(input logic [15:0] cmd, input int nBits, input bit commit,
                           output logic [15:0] rx);
    rx = '0;
    for (int i = 0; i < nBits; i++) begin
      int b = bLsb ? i : 15 - i;
      if (!bPha) begin
        sdi = cmd[b]; halfWait(); rx[b] = sdo; sclk = ~sclk;
        if (commit && i == 15) commitWord(cmd);
        halfWait(); sclk = ~sclk;
      end else begin
        sclk = ~sclk; sdi = cmd[b]; halfWait(); rx[b] = sdo; sclk = ~sclk;
        if (commit && i == 15) commitWord(cmd);
        halfWait();
      end
    end
  endtask

  task automatic xfer(input logic [15:0] cmd, input string tag);
    logic [15:0] rx;
    logic [15:0] exp;
    exp = pendReply;
    shiftBits(cmd, 16, 1'b1, rx);
    chk(rx == exp, tag, rx, exp);
  endtask

  task automatic selectOn();
    sclk = bPol; halfWait(); selN = 1'b0; halfWait();
  endtask

  task automatic selectOff();
    halfWait(); selN = 1'b1; pendReply = '0;
    {bPha, bPol, bLsb} = model[0][2:0];
    halfWait(); sclk = bPol; halfWait();
  endtask

  function automatic logic [15:0] wr(input int a, input logic [9:0] d);
    return {1'b0, 5'(a), d};
  endfunction
  function automatic logic [15:0] rd(input int a);
    return {1'b1, 5'(a), 10'h0};
  endfunction

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    {bPha, bPol, bLsb} = 3'b000; pendReply = '0; sclk = 1'b0;
    repeat (3) @(negedge clk); rstN = 1'b1; repeat (2) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [15:0] junk;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    live = 1'b1;
    chk(regsOut == '0, "R8 reset bank", regsOut, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(sdoOe == 1'b0, "R4 idle disabled", sdoOe, 0);

    // mode 0, MSB first: writes, reads, gap, out-of-range
    selectOn();
    xfer(wr(1, 10'h2A5), "R3 first reply zero");
    xfer(wr(2, 10'h155), "R3 reply after write");
    xfer(rd(1), "R3 reply after write");
    repeat (6) @(negedge clk);
    xfer(rd(2), "R2 read r1 after gap");
    xfer(wr(20, 10'h3FF), "R2 read r2");
    xfer(rd(20), "R3 write out of range");
    xfer(rd(1), "R3 read out of range");
    xfer(rd(0), "R2 read r1 again");
    selectOff();

    // select high drops the pending reply and a partial word
    selectOn();
    xfer(rd(1), "R3 first word");
    selectOff();
    selectOn();
    xfer(rd(2), "R4 reply dropped by select");
    shiftBits(wr(1, 10'h000), 8, 1'b0, junk);
    selectOff();
    selectOn();
    xfer(rd(1), "R4 first after abort");
    xfer(rd(1), "R4 partial word had no effect");
    selectOff();

    // mode write takes effect only after select rises
    selectOn();
    xfer(wr(0, 10'h001), "R5 reply zero");
    xfer(rd(1), "R5 old order still active");
    xfer(rd(2), "R5 old order reply");
    selectOff();
    selectOn();
    xfer(rd(1), "R6 LSB first");
    xfer(rd(2), "R6 LSB first reply r1");
    xfer(wr(3, 10'h0F3), "R6 LSB first reply r2");
    xfer(rd(3), "R6 LSB after write");
    xfer(rd(0), "R6 LSB read r3");
    selectOff();

    // remaining clocking schemes
    for (int m = 1; m < 4; m++) begin
      logic [2:0] md;
      md = {m[1], m[0], (m == 2)};
      selectOn();
      xfer(wr(0, {7'b0, md}), "R7 set mode");
      selectOff();
      selectOn();
      xfer(wr(3, 10'(10'h100 + m * 10'h41)), "R7 first word");
      xfer(rd(3), "R7 after write");
      repeat (3) @(negedge clk);
      xfer(rd(1), "R7 read r3");
      xfer(rd(0), "R7 read r1");
      xfer(rd(4), "R7 read mode");
      selectOff();
    end

    // power-on reset clears bank and mode
    doReset();
    chk(regsOut == '0, "R8 bank cleared", regsOut, 0);
    selectOn();
    xfer(rd(1), "R8 mode 0 restored");
    xfer(rd(0), "R8 r1 cleared");
    xfer(wr(5, 10'h2C1), "R8 r0 cleared");
    xfer(rd(5), "R8 write after reset");
    xfer(rd(5), "R8 read back");
    selectOff();

    finishRun();
  end
endmodule